// File: doc/BRIEF.md
# SPI Serial Memory Command Front End

This block is the serial side of a byte-addressed nonvolatile memory model. It acts as an SPI mode-0 slave. SI is sampled on rising SCK and SO changes on falling SCK. Every transaction opens with chip select going low. The block then takes in an 8-bit instruction, most significant bit first, and decodes it. When the instruction needs an address, it gathers a 16-bit address. It then streams array bytes or status bytes back on SO, or passes incoming bytes to the protection and programming logic around it.

The block holds no storage and no protection state. Array data comes in through a combinational read port (`mem_addr` / `mem_rdata`). The write-enable latch, block-protect bits and status-protect bit live in a neighbouring protection unit, which reports them on `st_*`. The programming unit reports an internal write cycle on `busy`. This block turns serial commands into one-cycle request pulses for those units. All of its logic runs on the system clock `clk`, and it finds SCK and chip-select edges by comparing each sample with the previous one.

Top module: `spi_mem_cmd`

## Requirements
- R1: After reset, and whenever chip select has been high for two consecutive clock samples, `so_oe` is 0 and no request pulse is asserted.
- R2: Opcode bit 3 is ignored. 0000x110 produces a single `wen_set` pulse, and 0000x100 produces a single `wen_clr` pulse.
- R3: Opcode 0000x101 returns the status byte {st_wpen, 3'b000, st_bp[1:0], st_wen, 1'b0} on SO, MSB first. The same byte repeats for as long as SCK keeps toggling.
- R4: While `busy` is 1, a status read returns 8'hFF. Any other opcode that arrives while busy produces no pulse and leaves SO undriven.
- R5: Opcode 0000x011 is followed by a 16-bit address, MSB first. Only the low AW bits of that address are used. Data at that address then leaves on SO, MSB first, with each bit changing on falling SCK. SI is ignored during this data phase.
- R6: During a read, the address goes up by one after each byte. After the top address it wraps to 0.
- R7: Opcode 0000x001, followed by one data byte, produces one `sr_wr` pulse, with that byte on `sr_data`.
- R8: Opcode 0000x010 is followed by an address and then data bytes. Each complete byte produces one `wr_byte` pulse carrying `wr_addr` and `wr_data`. Between bytes, the low PW address bits increment and wrap within the page, and the upper bits stay fixed.
- R9: `wr_commit` pulses once when chip select rises on a byte boundary, after at least one write byte. It does not pulse when chip select rises part-way through a byte.
- R10: An unrecognised opcode leaves the block inert until chip select rises. It produces no pulses and never drives SO.
- R11: SO is undriven (`so_oe` 0) throughout the opcode and address phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for SO; 0 means high impedance |
| mem_addr | output | AW | Array read address |
| mem_rdata | input | 8 | Array read data (combinational) |
| busy | input | 1 | Internal write cycle in progress |
| st_wpen | input | 1 | Status-protect enable bit |
| st_bp | input | 2 | Block-protect level |
| st_wen | input | 1 | Write-enable latch |
| wen_set | output | 1 | Request to set the write-enable latch |
| wen_clr | output | 1 | Request to clear the write-enable latch |
| sr_wr | output | 1 | Status-write request |
| sr_data | output | 8 | Status-write byte |
| wr_byte | output | 1 | One write byte received |
| wr_addr | output | AW | Address for that byte |
| wr_data | output | 8 | Write byte value |
| wr_commit | output | 1 | Start programming (chip select rose on a byte boundary) |

## Verification
The bench targets these corner cases, each paired with the failure it would expose:
- Opcodes with bit 3 set. A design that decoded all eight bits would drop these opcodes.
- A read starting just below the top of the array. A design with a page-limited read counter would repeat bytes where the array should wrap to 0.
- A write that crosses a page end. A design that carried into the upper address bits would report an address outside the page.
- Chip select rising in the middle of a write byte. A careless design would still start programming.
- Commands issued while `busy` is high. A design that failed to gate them would send write-enable pulses or drive SO, instead of returning only the all-ones status.

Every clock cycle in which chip select stays high is also checked for an undriven SO.

// File: rtl/spi_mem_cmd.sv
module spi_mem_cmd #(
  parameter int AW = 15,
  parameter int PW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          sck,
  input  logic          si,
  output logic          so,
  output logic          so_oe,
  output logic [AW-1:0] mem_addr,
  input  logic [7:0]    mem_rdata,
  input  logic          busy,
  input  logic          st_wpen,
  input  logic [1:0]    st_bp,
  input  logic          st_wen,
  output logic          wen_set,
  output logic          wen_clr,
  output logic          sr_wr,
  output logic [7:0]    sr_data,
  output logic          wr_byte,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          wr_commit
);

  typedef enum logic [2:0] {S_IDLE, S_OP, S_ADDR, S_RD, S_STAT, S_SRW, S_WR, S_DEAD} st_t;

  localparam logic [6:0] OP_WREN = 7'b0000110;
  localparam logic [6:0] OP_WRDI = 7'b0000100;
  localparam logic [6:0] OP_RDSR = 7'b0000101;
  localparam logic [6:0] OP_WRSR = 7'b0000001;
  localparam logic [6:0] OP_READ = 7'b0000011;
  localparam logic [6:0] OP_PROG = 7'b0000010;

  st_t          st;
  logic         cs_q, sck_q, is_wr, got, drv, so_r;
  logic [3:0]   cnt;
  logic [15:0]  sh;
  logic [AW-1:0] addr;
  logic [6:0]   oreg;
  logic [2:0]   ocnt;

  wire rise = sck & ~sck_q & ~cs_n;
  wire fall = ~sck & sck_q & ~cs_n;
  wire [15:0] shin = {sh[14:0], si};
  wire [6:0]  op = {shin[7:4], shin[2:0]};
  wire [7:0]  stat_byte = busy ? 8'hFF : {st_wpen, 3'b000, st_bp, st_wen, 1'b0};
  wire [PW-1:0] pg_next = addr[PW-1:0] + 1'b1;
  wire [AW-1:0] addr_pg = {addr[AW-1:PW], pg_next};
  wire [7:0]  out_byte = (st == S_RD) ? mem_rdata : stat_byte;

  assign so       = so_r;
  assign so_oe    = drv && (st == S_RD || st == S_STAT);
  assign mem_addr = addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cs_q <= 1'b1; sck_q <= 1'b0;
      cnt <= '0; sh <= '0; addr <= '0; is_wr <= 1'b0; got <= 1'b0;
      drv <= 1'b0; so_r <= 1'b0; oreg <= '0; ocnt <= '0;
      wen_set <= 1'b0; wen_clr <= 1'b0; sr_wr <= 1'b0; sr_data <= '0;
      wr_byte <= 1'b0; wr_addr <= '0; wr_data <= '0; wr_commit <= 1'b0;
    end else begin
      cs_q <= cs_n;
      sck_q <= sck;
      wen_set <= 1'b0; wen_clr <= 1'b0; sr_wr <= 1'b0;
      wr_byte <= 1'b0; wr_commit <= 1'b0;
      if (cs_n) begin
        if (st == S_WR && cnt == 4'd0 && got) wr_commit <= 1'b1;
        st <= S_IDLE; got <= 1'b0; drv <= 1'b0;
      end else if (cs_q) begin
        st <= S_OP; cnt <= '0; drv <= 1'b0; ocnt <= '0; got <= 1'b0;
      end else begin
        if (rise && (st == S_OP || st == S_ADDR || st == S_SRW || st == S_WR)) begin
          sh  <= shin;
          cnt <= cnt + 1'b1;
          case (st)
            S_OP: if (cnt == 4'd7) begin
              cnt <= '0;
              if (busy && op != OP_RDSR) st <= S_DEAD;
              else begin
                case (op)
                  OP_WREN: begin wen_set <= 1'b1; st <= S_DEAD; end
                  OP_WRDI: begin wen_clr <= 1'b1; st <= S_DEAD; end
                  OP_RDSR: st <= S_STAT;
                  OP_WRSR: st <= S_SRW;
                  OP_READ: begin is_wr <= 1'b0; st <= S_ADDR; end
                  OP_PROG: begin is_wr <= 1'b1; st <= S_ADDR; end
                  default: st <= S_DEAD;
                endcase
              end
            end
            S_ADDR: if (cnt == 4'd15) begin
              cnt  <= '0;
              addr <= shin[AW-1:0];
              st   <= is_wr ? S_WR : S_RD;
            end
            S_SRW: if (cnt == 4'd7) begin
              sr_wr <= 1'b1; sr_data <= shin[7:0]; st <= S_DEAD;
            end
            S_WR: if (cnt == 4'd7) begin
              cnt <= '0;
              wr_byte <= 1'b1; wr_data <= shin[7:0]; wr_addr <= addr;
              addr <= addr_pg; got <= 1'b1;
            end
            default: ;
          endcase
        end
        if (fall && (st == S_RD || st == S_STAT)) begin
          drv <= 1'b1;
          if (ocnt == 3'd0) begin
            so_r <= out_byte[7];
            oreg <= out_byte[6:0];
            ocnt <= 3'd7;
            if (st == S_RD) addr <= addr + 1'b1;
          end else begin
            so_r <= oreg[6];
            oreg <= {oreg[5:0], 1'b0};
            ocnt <= ocnt - 1'b1;
          end
        end
      end
    end
  end

  assert_hiz_deselected_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_q && cs_n) |-> !so_oe);
  assert_no_drive_after_select_R11: assert property (@(posedge clk) disable iff (!rst_n)
    so_oe |-> !cs_q);
  assert_single_request_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wen_set, wen_clr, sr_wr, wr_byte, wr_commit}));
  assert_busy_blocks_wen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wen_set || wen_clr || sr_wr) |-> $past(!busy));
  assert_commit_on_deselect_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |-> $past(cs_n));

endmodule

// File: tb/spi_mem_cmd_tb.sv
module spi_mem_cmd_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int PW = 4;

  logic clk = 0, rst_n = 0, cs_n = 1, sck = 0, si = 0;
  logic so, so_oe, busy = 0, st_wpen = 0, st_wen = 0;
  logic [1:0] st_bp = 0;
  logic [AW-1:0] mem_addr, wr_addr;
  logic [7:0] mem_rdata, sr_data, wr_data;
  logic wen_set, wen_clr, sr_wr, wr_byte, wr_commit;

  int checks = 0, fails = 0;
  int n_set = 0, n_clr = 0, n_commit = 0;
  logic [15:0] obs_wr[$];
  logic [7:0]  obs_sr[$];
  int oe_cnt;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] f(input logic [7:0] a);
    return (a * 8'd37) ^ 8'h5A;
  endfunction
  assign mem_rdata = f(mem_addr);

  spi_mem_cmd #(.AW(AW), .PW(PW)) u_dut (
    .clk, .rst_n, .cs_n, .sck, .si, .so, .so_oe, .mem_addr, .mem_rdata,
    .busy, .st_wpen, .st_bp, .st_wen, .wen_set, .wen_clr, .sr_wr, .sr_data,
    .wr_byte, .wr_addr, .wr_data, .wr_commit);

  always @(posedge clk) if (rst_n) begin
    if (wen_set) n_set++;
    if (wen_clr) n_clr++;
    if (wr_commit) n_commit++;
    if (sr_wr) obs_sr.push_back(sr_data);
    if (wr_byte) obs_wr.push_back({wr_addr, wr_data});
  end

  logic cs_prev = 1;
  always @(negedge clk) begin
    if (rst_n && cs_n && cs_prev) begin
      checks++;
      if (so_oe !== 1'b0) begin
        fails++;
        $display("FAIL R1: so_oe=%b expected 0 while deselected", so_oe);
      end
    end
    cs_prev <= cs_n;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk); sck = 0; si = tx[i];
      repeat (3) @(negedge clk);
      rx[i] = so; if (so_oe === 1'b1) oe_cnt++;
      sck = 1;
      repeat (3) @(negedge clk);
    end
  endtask

  task automatic bits(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); sck = 0; si = 1;
      repeat (3) @(negedge clk); sck = 1;
      repeat (3) @(negedge clk);
    end
  endtask

  task automatic begin_tx();
    @(negedge clk); cs_n = 0; sck = 0; oe_cnt = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic end_tx();
    @(negedge clk); sck = 0;
    repeat (3) @(negedge clk); cs_n = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic read_test(input string req, input logic [15:0] a, input int nb);
    logic [7:0] rx;
    logic [7:0] ea;
    begin_tx();
    xfer(8'h0B, rx); xfer(a[15:8], rx); xfer(a[7:0], rx);
    chk("R11", oe_cnt, 0);
    ea = a[7:0];
    for (int k = 0; k < nb; k++) begin
      oe_cnt = 0;
      xfer(8'hA5, rx);
      chk(req, rx, f(ea));
      chk("R5", oe_cnt, 8);
      ea = ea + 1;
    end
    end_tx();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] rx;
    repeat (3) @(negedge clk);
    chk("R1", so_oe, 0);
    chk("R1", {wen_set, wen_clr, sr_wr, wr_byte, wr_commit}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R2: write-enable set/clear, bit 3 both ways
    begin_tx(); xfer(8'h06, rx); end_tx();
    begin_tx(); xfer(8'h0E, rx); end_tx();
    chk("R2", n_set, 2);
    begin_tx(); xfer(8'h0C, rx); end_tx();
    chk("R2", n_clr, 1);

    // R3: status repeats
    st_wpen = 1; st_bp = 2'b10; st_wen = 1;
    begin_tx(); xfer(8'h05, rx); chk("R11", oe_cnt, 0);
    xfer(8'h00, rx); chk("R3", rx, 8'h8A);
    xfer(8'hFF, rx); chk("R3", rx, 8'h8A);
    end_tx();

    // R5/R6: read with ignored upper bits, then top wrap
    read_test("R5", 16'hFF12, 2);
    read_test("R6", 16'h00FE, 3);

    // R7: status write
    begin_tx(); xfer(8'h01, rx); xfer(8'h8C, rx); end_tx();
    chk("R7", obs_sr.size(), 1);
    if (obs_sr.size() > 0) chk("R7", obs_sr.pop_front(), 8'h8C);

    // R8/R9: page write crossing page end
    begin_tx(); xfer(8'h02, rx); xfer(8'h00, rx); xfer(8'h3E, rx);
    xfer(8'hA1, rx); xfer(8'hB2, rx); xfer(8'hC3, rx); end_tx();
    chk("R8", obs_wr.size(), 3);
    if (obs_wr.size() == 3) begin
      chk("R8", obs_wr.pop_front(), 16'h3EA1);
      chk("R8", obs_wr.pop_front(), 16'h3FB2);
      chk("R8", obs_wr.pop_front(), 16'h30C3);
    end
    chk("R9", n_commit, 1);

    // R9: partial byte, no commit
    begin_tx(); xfer(8'h02, rx); xfer(8'h00, rx); xfer(8'h10, rx);
    xfer(8'h77, rx); bits(3); end_tx();
    chk("R9", n_commit, 1);
    chk("R8", obs_wr.size(), 1);
    void'(obs_wr.pop_front());

    // R10: unknown opcode
    begin_tx(); xfer(8'h07, rx); oe_cnt = 0;
    xfer(8'h06, rx); xfer(8'h01, rx); xfer(8'h55, rx); end_tx();
    chk("R10", oe_cnt, 0);
    chk("R10", n_set + obs_sr.size(), 2);

    // R4: busy behaviour
    busy = 1;
    begin_tx(); xfer(8'h05, rx); xfer(8'h00, rx); end_tx();
    chk("R4", rx, 8'hFF);
    begin_tx(); xfer(8'h06, rx); end_tx();
    chk("R4", n_set, 2);
    begin_tx(); xfer(8'h03, rx); xfer(8'h00, rx); xfer(8'h00, rx);
    oe_cnt = 0; xfer(8'h00, rx); end_tx();
    chk("R4", oe_cnt, 0);
    busy = 0;
    chk("R4", obs_wr.size() + obs_sr.size(), 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule